// File: doc/BRIEF.md
# Paired Reload Square-Wave Generator

This block drives two square-wave outputs from a pair of 8-bit reload counters. Each counter has a register for the low width and a separate register for the high width. While the output is low the counter counts down from the low width. On underflow the output goes high and the counter loads the high width. The next underflow returns the output to low. Each phase therefore lasts its reload value plus one count tick. Writes to the width registers do not disturb the count in progress; the new value is picked up at the next phase boundary.

The pair has three operating arrangements. In split mode the two counters run independently. In wide mode they act as one 16-bit generator whose widths join the two channels' registers. In prescale mode the first counter divides the count tick and feeds the second counter. The count tick comes either from the system clock divided by 1, 2, 4, 8 or 16, or from a slow external tick. The slow tick is synchronized and edge-detected before use. An end-of-period flag drives the interrupt output while the interrupt enable is set. Control pins are plain levels, and registers are written through a one-cycle write strobe with no back-pressure.

Top module: `pulse_pair_gen`

## Requirements
- R1: With `op_mode` 2'b00 or 2'b11 (split), channel A and channel B run independently. Each output stays low for (low width + 1) ticks and high for (high width + 1) ticks, using its own registers.
- R2: With `op_mode` 2'b01 (wide), `pulse_b` carries one 16-bit generator. Its low width is {reg2, reg0} and its high width is {reg3, reg1}, with channel B's register as the upper byte. `pulse_a` is held at `idle_level` in this mode.
- R3: With `op_mode` 2'b10 (prescale), channel A produces one count pulse every (reg0 + 1) ticks. Channel B counts these pulses using reg2 and reg3 as its widths. `pulse_a` is held at `idle_level`.
- R4: `tick_sel` values 0 to 4 give one count tick every 2^`tick_sel` system clocks.
- R5: `tick_sel` values 5 to 7 count on `slow_tick`. Each rising edge gives exactly one count tick, however long the input stays high.
- R6: A write to a width register does not change the phase in progress. The new value applies from the next load of that register.
- R7: While `run_en` is low, both outputs equal `idle_level` and the counters hold their low widths. When `run_en` goes high, outputs start in the low phase.
- R8: An end-of-period flag is set at the end of each high phase of the generator driving `pulse_b`. It stays set until a write to address 4 with data bit 0 equal to 1. `irq` equals the flag ANDed with `irq_en`.
- R9: Write addresses: 0 sets A low width, 1 sets A high width, 2 sets B low width, 3 sets B high width, and 4 is the flag clear. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| run_en | input | 1 | Pair enable |
| op_mode | input | 2 | 00/11 split, 01 wide, 10 prescale |
| tick_sel | input | 3 | Count tick source select |
| slow_tick | input | 1 | Asynchronous slow tick from oscillator domain |
| idle_level | input | 1 | Output level while disabled |
| irq_en | input | 1 | Interrupt enable |
| pulse_a | output | 1 | Channel A output |
| pulse_b | output | 1 | Channel B or combined output |
| irq | output | 1 | End-of-period interrupt |

## Verification
The bench measures steady-state high and low durations in clocks and compares them with widths predicted from the register values. This catches an off-by-one phase length or swapped low and high registers. A wide-mode case uses a width above 255, so a design that fails to join the bytes, or that joins them in the wrong order, produces a much shorter or wrong period. The slow tick is held high for several clocks, so a level-sensitive design would count it more than once. A width write in mid-phase must leave that phase at its old length. An interrupt flag left pending while `irq_en` is low must appear once `irq_en` goes high and must clear on the write.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT  = 2'b00,
    MODE_WIDE   = 2'b01,
    MODE_PRESC  = 2'b10,
    MODE_SPLIT2 = 2'b11
  } ppg_mode_e;

  localparam int unsigned REG_CNT   = 5;
  localparam int unsigned ADDR_CLR  = 4;
endpackage

// File: rtl/ppg_tick_gen.sv
module ppg_tick_gen #(
  parameter int unsigned DIV_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       slow_in,
  output logic       tick
);
  localparam int unsigned SLOW_SEL = DIV_W + 1;

  logic [DIV_W-1:0] div_q;
  logic [2:0]       sync_q;
  logic [DIV_W-1:0] mask;
  logic             slow_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sync_q <= '0;
    end else begin
      div_q  <= div_q + 1'b1;
      sync_q <= {sync_q[1:0], slow_in};
    end
  end

  assign slow_pulse = sync_q[1] & ~sync_q[2];
  assign mask       = ~({DIV_W{1'b1}} << sel);

  always_comb begin
    if (32'(sel) >= SLOW_SEL) tick = slow_pulse;
    else                      tick = ((div_q & mask) == mask);
  end
endmodule

// File: rtl/ppg_core.sv
module ppg_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] low_val,
  input  logic [W-1:0] high_val,
  output logic         level,
  output logic         tc,
  output logic         wrap
);
  logic [W-1:0] cnt_q;
  logic         phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!run) begin
      cnt_q   <= low_val;
      phase_q <= 1'b0;
    end else if (tick) begin
      if (cnt_q == '0) begin
        phase_q <= ~phase_q;
        cnt_q   <= phase_q ? low_val : high_val;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign level = phase_q;
  assign tc    = run & tick & (cnt_q == '0);
  assign wrap  = tc & phase_q;
endmodule

// File: rtl/pulse_pair_gen.sv
module pulse_pair_gen
  import ppg_pkg::*;
#(
  parameter int unsigned CH_W  = 8,
  parameter int unsigned DIV_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [CH_W-1:0] wr_data,
  input  logic            run_en,
  input  logic [1:0]      op_mode,
  input  logic [2:0]      tick_sel,
  input  logic            slow_tick,
  input  logic            idle_level,
  input  logic            irq_en,
  output logic            pulse_a,
  output logic            pulse_b,
  output logic            irq
);
  localparam int unsigned WIDE_W = 2 * CH_W;

  logic [CH_W-1:0] width_q [4];
  logic            flag_q;
  logic            tick;
  logic            is_wide, is_presc;
  logic            run_ch, run_wide;
  logic            lvl_a, lvl_b, lvl_w;
  logic            tc_a, tc_b, tc_w;
  logic            wrap_a, wrap_b, wrap_w;
  logic [CH_W-1:0] a_high;
  logic            b_tick;
  logic            end_period;
  logic            clr_hit;

  assign is_wide  = (ppg_mode_e'(op_mode) == MODE_WIDE);
  assign is_presc = (ppg_mode_e'(op_mode) == MODE_PRESC);
  assign run_ch   = run_en & ~is_wide;
  assign run_wide = run_en & is_wide;

  genvar gi;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   width_q[gi] <= '0;
        else if (wr_en && (32'(wr_addr) == gi))       width_q[gi] <= wr_data;
      end
    end
  endgenerate

  ppg_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .sel(tick_sel), .slow_in(slow_tick), .tick(tick)
  );

  assign a_high = is_presc ? width_q[0] : width_q[1];
  assign b_tick = is_presc ? tc_a : tick;

  ppg_core #(.W(CH_W)) u_ch_a (
    .clk(clk), .rst_n(rst_n), .run(run_ch), .tick(tick),
    .low_val(width_q[0]), .high_val(a_high),
    .level(lvl_a), .tc(tc_a), .wrap(wrap_a)
  );

  ppg_core #(.W(CH_W)) u_ch_b (
    .clk(clk), .rst_n(rst_n), .run(run_ch), .tick(b_tick),
    .low_val(width_q[2]), .high_val(width_q[3]),
    .level(lvl_b), .tc(tc_b), .wrap(wrap_b)
  );

  ppg_core #(.W(WIDE_W)) u_wide (
    .clk(clk), .rst_n(rst_n), .run(run_wide), .tick(tick),
    .low_val({width_q[2], width_q[0]}), .high_val({width_q[3], width_q[1]}),
    .level(lvl_w), .tc(tc_w), .wrap(wrap_w)
  );

  assign end_period = is_wide ? wrap_w : wrap_b;
  assign clr_hit    = wr_en && (32'(wr_addr) == ADDR_CLR) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (end_period) flag_q <= 1'b1;
    else if (clr_hit)    flag_q <= 1'b0;
  end

  always_comb begin
    pulse_a = idle_level;
    pulse_b = idle_level;
    if (run_en) begin
      pulse_a = (is_wide | is_presc) ? idle_level : lvl_a;
      pulse_b = is_wide ? lvl_w : lvl_b;
    end
  end

  assign irq = flag_q & irq_en;

  logic unused_ok;
  assign unused_ok = ^{tc_b, tc_w, wrap_a};
endmodule

// File: rtl/pulse_pair_gen_chk.sv
module pulse_pair_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       run_en,
  input logic [1:0] op_mode,
  input logic       idle_level,
  input logic       irq_en,
  input logic       pulse_a,
  input logic       pulse_b,
  input logic       irq
);
  // R7
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (pulse_a == idle_level && pulse_b == idle_level));

  // R2
  wide_a_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && op_mode == 2'b01) |-> (pulse_a == idle_level));

  // R3
  presc_a_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && op_mode == 2'b10) |-> (pulse_a == idle_level));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && wr_addr == 3'd4 && wr_data[0])) |=> (irq || !irq_en));
endmodule

bind pulse_pair_gen pulse_pair_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .run_en(run_en), .op_mode(op_mode), .idle_level(idle_level), .irq_en(irq_en),
  .pulse_a(pulse_a), .pulse_b(pulse_b), .irq(irq)
);

// File: tb/pulse_pair_gen_tb.sv
module pulse_pair_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       run_en = 1'b0;
  logic [1:0] op_mode = '0;
  logic [2:0] tick_sel = '0;
  logic       slow_tick = 1'b0;
  logic       idle_level = 1'b0;
  logic       irq_en = 1'b0;
  logic       pulse_a, pulse_b, irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit osc_on = 1'b0;
  bit done   = 1'b0;

  typedef struct { int hi; int lo; string tag; } exp_t;
  exp_t sb_q[$];

  pulse_pair_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run_en(run_en), .op_mode(op_mode), .tick_sel(tick_sel), .slow_tick(slow_tick),
    .idle_level(idle_level), .irq_en(irq_en),
    .pulse_a(pulse_a), .pulse_b(pulse_b), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG && !done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    forever begin
      repeat (7) @(negedge clk);
      if (osc_on) slow_tick = 1'b1;
      repeat (3) @(negedge clk);
      slow_tick = 1'b0;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input bit use_b, output int hi, output int lo);
    hi = 0; lo = 0;
    do @(negedge clk); while ((use_b ? pulse_b : pulse_a) !== 1'b0);
    do @(negedge clk); while ((use_b ? pulse_b : pulse_a) !== 1'b1);
    while ((use_b ? pulse_b : pulse_a) === 1'b1) begin hi++; @(negedge clk); end
    while ((use_b ? pulse_b : pulse_a) === 1'b0) begin lo++; @(negedge clk); end
  endtask

  // monitor: pops expected pulse_b shapes and compares to measured ones
  initial begin
    forever begin
      int h, l;
      exp_t e;
      wait (sb_q.size() > 0);
      measure(1'b1, h, l);
      e = sb_q.pop_front();
      check(h == e.hi, {e.tag, " high"}, h, e.hi);
      check(l == e.lo, {e.tag, " low"}, l, e.lo);
    end
  end

  task automatic expect_b(input int hi, input int lo, input string tag);
    exp_t e;
    e.hi = hi; e.lo = lo; e.tag = tag;
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
  endtask

  task automatic stop_run();
    @(negedge clk);
    run_en = 1'b0;
  endtask

  initial begin
    int h, l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 R9: reset state, outputs at idle
    check(pulse_a == 1'b0 && pulse_b == 1'b0, "R7 reset idle", {pulse_a, pulse_b}, 0);
    check(irq == 1'b0, "R8 reset irq", irq, 0);

    // R7: idle level followed while disabled
    idle_level = 1'b1;
    @(negedge clk);
    check(pulse_a == 1'b1 && pulse_b == 1'b1, "R7 idle high", {pulse_a, pulse_b}, 3);

    // R1 R9: split mode, distinct widths per channel
    wr(3'd0, 8'd3); wr(3'd1, 8'd1); wr(3'd2, 8'd4); wr(3'd3, 8'd6);
    op_mode = 2'b00; tick_sel = 3'd0;
    @(negedge clk); run_en = 1'b1;
    @(negedge clk);
    check(pulse_a == 1'b0 && pulse_b == 1'b0, "R7 start low", {pulse_a, pulse_b}, 0);
    measure(1'b0, h, l);
    check(h == 2 && l == 4, "R1 chA shape", h * 1000 + l, 2004);
    expect_b(7, 5, "R1 chB");
    stop_run();

    // R1: mode 2'b11 also split
    op_mode = 2'b11;
    @(negedge clk); run_en = 1'b1;
    expect_b(7, 5, "R1 split alt");
    stop_run();

    // R4: divide by 4
    op_mode = 2'b00; tick_sel = 3'd2;
    wr(3'd2, 8'd2); wr(3'd3, 8'd1);
    @(negedge clk); run_en = 1'b1;
    expect_b(8, 12, "R4 div4");
    stop_run();
    // R4: divide by 16
    tick_sel = 3'd4;
    @(negedge clk); run_en = 1'b1;
    expect_b(32, 48, "R4 div16");
    stop_run();

    // R2: wide mode low={reg2,reg0}=0x0104=260, high={reg3,reg1}=3
    wr(3'd0, 8'd4); wr(3'd2, 8'd1); wr(3'd1, 8'd3); wr(3'd3, 8'd0);
    op_mode = 2'b01; tick_sel = 3'd0;
    @(negedge clk); run_en = 1'b1;
    expect_b(4, 261, "R2 wide");
    check(pulse_a == idle_level, "R2 pulse_a idle", pulse_a, idle_level);
    stop_run();

    // R3: prescale reg0=2 -> every 3 clocks; B low=1, high=2
    wr(3'd0, 8'd2); wr(3'd2, 8'd1); wr(3'd3, 8'd2);
    op_mode = 2'b10;
    @(negedge clk); run_en = 1'b1;
    expect_b(9, 6, "R3 prescale");
    check(pulse_a == idle_level, "R3 pulse_a idle", pulse_a, idle_level);
    stop_run();

    // R5: slow tick every 10 clocks, held high 3 clocks
    op_mode = 2'b00; tick_sel = 3'd5;
    osc_on = 1'b1;
    @(negedge clk); run_en = 1'b1;
    expect_b(30, 20, "R5 slow tick");
    stop_run();
    osc_on = 1'b0;

    // R6: mid-phase write of A high width
    tick_sel = 3'd0;
    wr(3'd0, 8'd20); wr(3'd1, 8'd20);
    @(negedge clk); run_en = 1'b1;
    begin
      int c1, c2, c3;
      c1 = 0; c2 = 0; c3 = 0;
      do @(negedge clk); while (pulse_a !== 1'b1);
      while (pulse_a === 1'b1) begin
        c1++;
        if (c1 == 3) begin wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'd5; end
        if (c1 == 4) wr_en = 1'b0;
        @(negedge clk);
      end
      while (pulse_a === 1'b0) begin c2++; @(negedge clk); end
      while (pulse_a === 1'b1) begin c3++; @(negedge clk); end
      check(c1 == 21, "R6 phase kept", c1, 21);
      check(c2 == 21, "R6 low unchanged", c2, 21);
      check(c3 == 6, "R6 new width", c3, 6);
    end
    stop_run();

    // R8: flag pending with irq_en low, then visible, then cleared
    wr(3'd2, 8'd1); wr(3'd3, 8'd1);
    irq_en = 1'b0;
    @(negedge clk); run_en = 1'b1;
    repeat (20) @(negedge clk);
    check(irq == 1'b0, "R8 masked", irq, 0);
    stop_run();
    irq_en = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R8 pending", irq, 1);
    wr(3'd4, 8'd0);
    check(irq == 1'b1, "R8 clear bit0 zero ignored", irq, 1);
    wr(3'd4, 8'd1);
    check(irq == 1'b0, "R8 cleared", irq, 0);
    check(pulse_a == 1'b1 && pulse_b == 1'b1, "R7 idle after stop", {pulse_a, pulse_b}, 3);

    done = 1'b1;
    finish_run();
  end
endmodule